// File: doc/BRIEF.md
# Link Controller Control Register

A single 32-bit control word for a serial memory-link controller, mapped at byte offset 0x04 of a simple register bus (address, write strobe, write data, read strobe, read data). Two bits are persistent read/write fields that drive lines toward the attached memory device: an active-low device reset and a transmit power-state level. While the core's own reset input is asserted, the device reset line is forced low and the power-state line is forced high. Once the core reset is released, both lines follow their fields.

Five further bits are commands that software can only write. Four of them (link retrain, release of a fatal retry halt, core soft reset and forced receive error) become one-cycle pulses to the consumers in the core. The fifth arms a single-bit CRC corruption that waits for the next request packet. Reads return only the two persistent fields. Every command bit and every unused bit reads as zero.

Top module: `link_ctrl_reg`

## Requirements
- R1: The block responds only to bus address 0x04. A write to any other address leaves both fields and the CRC arm state unchanged and issues no pulse. A read at any other address returns 0.
- R2: Bit 17 is the device-reset field. It is 1 after reset, it is loaded from write data bit 17, and `dev_rst_n` equals it while `rst_n` is high.
- R3: While `rst_n` is low, `dev_rst_n` is 0 and `tx_pwr_state` is 1, whatever the field values. Both fields return to 1.
- R4: Bit 16 is the transmit power-state field. It is 1 after reset, it is loaded from write data bit 16, and `tx_pwr_state` equals it while `rst_n` is high.
- R5: A write to 0x04 with bit 0 (retrain), bit 1 (clear fatal), bit 2 (soft reset) or bit 9 (force receive error) set produces exactly one cycle of the matching pulse output, in the cycle after the write. Several bits in one write produce their pulses together. The clear-fatal pulse is issued unconditionally.
- R6: Command bits 9, 8, 2, 1 and 0 and reserved bits 31:18, 15:10 and 7:3 always read back as 0. Writing 1s to the reserved bits has no effect.
- R7: A write with bit 8 set arms CRC injection from the next cycle on. `crc_inject_armed` stays high until a cycle with `pkt_start` high. In that cycle `crc_inject_fire` is high, and the arm is cleared from the next cycle on.
- R8: Writing bit 8 again while the injection is armed does not stack. A single `pkt_start` clears the arm, and only one fire occurs. If a new arming write falls in the same cycle as a consuming `pkt_start`, the arm stays set.
- R9: Read data is registered. In the cycle after `bus_rd` with address 0x04, `bus_rdata` holds the field values from before any write in the same cycle. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, active low, asynchronous assert |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pkt_start | input | 1 | Start strobe of an outgoing request packet |
| dev_rst_n | output | 1 | Device reset, active low |
| tx_pwr_state | output | 1 | Transmit power-state level to device |
| pulse_retrain | output | 1 | Link retrain pulse |
| pulse_clr_fatal | output | 1 | Release-fatal-halt pulse for the retry machine |
| pulse_soft_rst | output | 1 | Core soft-reset pulse |
| pulse_force_rxerr | output | 1 | Forced receive-error pulse |
| crc_inject_armed | output | 1 | CRC corruption pending |
| crc_inject_fire | output | 1 | Corrupt CRC of the packet starting this cycle |

## Verification
The hardest cases to reach are those where the arm state meets a second event: a re-arming write while injection is already pending, or an arming write in the same cycle as a consuming `pkt_start`. The seeded random stream writes often to 0x04, sets bit 8 with high probability and raises `pkt_start` about a quarter of the time, so these overlaps happen many times. Directed sequences also force the double arm followed by a single consume. A directed sequence asserts the core reset while both fields hold 0, which shows that the override is visible at the outputs.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
   localparam int unsigned LCR_MIN_W     = 18;
   localparam int unsigned LCR_POS_DEV   = 17;
   localparam int unsigned LCR_POS_PWR   = 16;
   localparam int unsigned LCR_POS_CRC   = 8;
   localparam int unsigned LCR_NCMD      = 4;
   // pulse index: 0 retrain, 1 clear fatal, 2 soft reset, 3 force rx error
   localparam int unsigned LCR_CMD_POS [LCR_NCMD] = '{0, 1, 2, 9};

   typedef struct packed {
      logic dev_rst;
      logic tx_pwr;
   } lcr_fields_t;
endpackage

// File: rtl/lcr_field_bank.sv
module lcr_field_bank
   import lcr_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output lcr_fields_t       fields_q,
   output logic              dev_rst_n,
   output logic              tx_pwr_state
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fields_q <= '{dev_rst: 1'b1, tx_pwr: 1'b1};
      end else if (wr_hit) begin
         fields_q.dev_rst <= wdata[LCR_POS_DEV];
         fields_q.tx_pwr  <= wdata[LCR_POS_PWR];
      end
   end

   assign dev_rst_n    = rst_n & fields_q.dev_rst;
   assign tx_pwr_state = ~rst_n | fields_q.tx_pwr;

   AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(fields_q)); // R1
   AST_DEV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> dev_rst_n == $past(wdata[LCR_POS_DEV])); // R2
   AST_PWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> tx_pwr_state == $past(wdata[LCR_POS_PWR])); // R4
endmodule

// File: rtl/lcr_cmd_pulser.sv
module lcr_cmd_pulser
   import lcr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NCMD   = LCR_NCMD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [NCMD-1:0]   pulse_q
);
   for (genvar i = 0; i < NCMD; i++) begin : g_cmd
      localparam int unsigned POS = LCR_CMD_POS[i];
      if (POS >= DATA_W) begin : g_bad
         $error("command bit position outside data width");
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q[i] <= 1'b0;
         else        pulse_q[i] <= wr_hit & wdata[POS];
      end

      AST_PULSE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && wdata[POS]) |=> pulse_q[i]); // R5
      AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_hit && wdata[POS]) |=> !pulse_q[i]); // R5
   end
endmodule

// File: rtl/lcr_crc_arm.sv
module lcr_crc_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic pkt_start,
   output logic armed_q,
   output logic fire
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= set_req | (armed_q & ~pkt_start);
   end

   assign fire = armed_q & pkt_start;

   AST_ARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> armed_q); // R7
   AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !pkt_start) |=> armed_q); // R7
   AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && pkt_start && !set_req) |=> !armed_q); // R8
endmodule

// File: rtl/link_ctrl_reg.sv
module link_ctrl_reg
   import lcr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned REG_ADDR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pkt_start,
   output logic              dev_rst_n,
   output logic              tx_pwr_state,
   output logic              pulse_retrain,
   output logic              pulse_clr_fatal,
   output logic              pulse_soft_rst,
   output logic              pulse_force_rxerr,
   output logic              crc_inject_armed,
   output logic              crc_inject_fire
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   if (DATA_W < LCR_MIN_W) begin : g_bad_width
      $error("DATA_W too small for the control fields");
   end
   if (REG_ADDR >= (1 << ADDR_W) || (REG_ADDR % 4) != 0) begin : g_bad_addr
      $error("REG_ADDR must be word aligned and inside the address space");
   end

   logic            addr_hit, wr_hit, rd_hit;
   lcr_fields_t     fields_q;
   logic [LCR_NCMD-1:0] pulses;

   assign addr_hit = (bus_addr == HIT_ADDR);
   assign wr_hit   = bus_wr & addr_hit;
   assign rd_hit   = bus_rd & addr_hit;

   lcr_field_bank #(.DATA_W(DATA_W)) u_fields (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(bus_wdata),
      .fields_q(fields_q), .dev_rst_n(dev_rst_n), .tx_pwr_state(tx_pwr_state)
   );

   lcr_cmd_pulser #(.DATA_W(DATA_W), .NCMD(LCR_NCMD)) u_pulser (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(bus_wdata),
      .pulse_q(pulses)
   );

   assign pulse_retrain     = pulses[0];
   assign pulse_clr_fatal   = pulses[1];
   assign pulse_soft_rst    = pulses[2];
   assign pulse_force_rxerr = pulses[3];

   lcr_crc_arm u_crc (
      .clk(clk), .rst_n(rst_n),
      .set_req(wr_hit & bus_wdata[LCR_POS_CRC]),
      .pkt_start(pkt_start),
      .armed_q(crc_inject_armed), .fire(crc_inject_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else begin
         bus_rdata <= '0;
         if (rd_hit) begin
            bus_rdata[LCR_POS_DEV] <= fields_q.dev_rst;
            bus_rdata[LCR_POS_PWR] <= fields_q.tx_pwr;
         end
      end
   end

   always_comb begin
      if (!rst_n) begin
         AST_RST_OVERRIDE: assert (!dev_rst_n && tx_pwr_state); // R3
      end
   end
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> bus_rdata == '0); // R9
   AST_RD_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> bus_rdata[LCR_POS_DEV] == $past(dev_rst_n)); // R9
   AST_RD_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (bus_rdata[LCR_POS_CRC] == 1'b0 && bus_rdata[2:0] == 3'b000)); // R6
endmodule

// File: tb/link_ctrl_reg_test.sv
`timescale 1ns/1ps
module link_ctrl_reg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        pkt_start = 1'b0;
   logic        dev_rst_n, tx_pwr_state;
   logic        pulse_retrain, pulse_clr_fatal, pulse_soft_rst, pulse_force_rxerr;
   logic        crc_inject_armed, crc_inject_fire;

   int checks = 0;
   int errors = 0;

   logic m_dev = 1'b1, m_pwr = 1'b1, m_arm = 1'b0;

   always #10 clk = ~clk;

   link_ctrl_reg uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pkt_start(pkt_start), .dev_rst_n(dev_rst_n), .tx_pwr_state(tx_pwr_state),
      .pulse_retrain(pulse_retrain), .pulse_clr_fatal(pulse_clr_fatal),
      .pulse_soft_rst(pulse_soft_rst), .pulse_force_rxerr(pulse_force_rxerr),
      .crc_inject_armed(crc_inject_armed), .crc_inject_fire(crc_inject_fire)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic rd, input logic [7:0] a);
      logic [31:0] v = '0;
      if (rd && a == 8'h04) begin
         v[17] = m_dev;
         v[16] = m_pwr;
      end
      return v;
   endfunction

   function automatic logic [3:0] exp_pulses(input logic wr, input logic [7:0] a,
                                             input logic [31:0] d);
      if (wr && a == 8'h04) return {d[9], d[2], d[1], d[0]};
      return 4'b0;
   endfunction

   task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [31:0] d, input logic pk);
      logic [31:0] er;
      logic [3:0]  ep;
      logic        hit;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; pkt_start = pk;
      #1;
      chk("R7 fire", {31'b0, crc_inject_fire}, {31'b0, m_arm & pk});
      hit = wr && (a == 8'h04);
      er  = exp_read(rd, a);
      ep  = exp_pulses(wr, a, d);
      if (hit) begin
         m_dev = d[17];
         m_pwr = d[16];
      end
      m_arm = (hit & d[8]) | (m_arm & ~pk);
      @(negedge clk);
      chk("R9 rdata", bus_rdata, er);
      chk("R5 pulses", {28'b0, pulse_force_rxerr, pulse_soft_rst, pulse_clr_fatal, pulse_retrain},
          {28'b0, ep});
      chk("R2 dev_rst_n", {31'b0, dev_rst_n}, {31'b0, m_dev});
      chk("R4 tx_pwr", {31'b0, tx_pwr_state}, {31'b0, m_pwr});
      chk("R8 armed", {31'b0, crc_inject_armed}, {31'b0, m_arm});
   endtask

   task automatic idle();
      step(1'b0, 1'b0, 8'h00, 32'h0, 1'b0);
   endtask

   initial begin
      void'($urandom(32'd24681));
      #5;
      chk("R3 reset dev low", {31'b0, dev_rst_n}, 32'd0);
      chk("R3 reset pwr high", {31'b0, tx_pwr_state}, 32'd1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // reset values
      step(1'b0, 1'b1, 8'h04, 32'h0, 1'b0);
      step(1'b0, 1'b0, 8'h00, 32'h0, 1'b0);
      // R6: all ones, then read back fields only
      step(1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF, 1'b0);
      step(1'b0, 1'b1, 8'h04, 32'h0, 1'b0);
      chk("R6 readback", bus_rdata, 32'h0003_0000);
      // R1: write other offset, read other offset
      step(1'b1, 1'b0, 8'h08, 32'h0000_0307, 1'b0);
      chk("R1 no pulse", {28'b0, pulse_force_rxerr, pulse_soft_rst, pulse_clr_fatal, pulse_retrain}, 32'd0);
      step(1'b0, 1'b1, 8'h00, 32'h0, 1'b0);
      chk("R1 read other", bus_rdata, 32'h0);
      // R8: consume earlier arm, double arm, single consume
      step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
      step(1'b1, 1'b0, 8'h04, 32'h0003_0100, 1'b0);
      step(1'b1, 1'b0, 8'h04, 32'h0003_0100, 1'b0);
      step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
      chk("R8 single consume", {31'b0, crc_inject_armed}, 32'd0);
      step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
      // R9: read in same cycle as write returns old values
      step(1'b1, 1'b1, 8'h04, 32'h0, 1'b0);
      chk("R9 old value", bus_rdata, 32'h0003_0000);
      // R3: override while fields are 0
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R3 override dev", {31'b0, dev_rst_n}, 32'd0);
      chk("R3 override pwr", {31'b0, tx_pwr_state}, 32'd1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_dev = 1'b1; m_pwr = 1'b1; m_arm = 1'b0;
      idle();
      // random traffic
      for (int i = 0; i < 2000; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = ($urandom_range(0, 9) < 6) ? 8'h04 : 8'($urandom);
         d = $urandom;
         if ($urandom_range(0, 3) == 0) d[8] = 1'b1;
         step($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a, d,
              $urandom_range(0, 3) == 0);
      end
      idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog R9 actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule